// File: doc/BRIEF.md
# Video Gain Mode Controller with Sync-Loss Policy

This block holds the gain-control mode for a video front end, together with a policy that decides what happens to that mode when sync lock is lost or regained. The mode selects which gain word reaches the amplifier. There are four sources: a fixed unity gain, the live word from the automatic gain loop, a gain word programmed by software, or an automatic gain value captured once and then held.

Software writes the mode and the policy through a single write strobe. Two event pulses from the sync detector, lock lost and lock achieved, can make the hardware rewrite the mode field itself. The readback port always shows the mode that is driving the gain output, so software sees each hardware rewrite as soon as it takes effect. The automatic gain loop is outside this block. It only supplies its current gain word.

Top module: `gain_mode_ctrl`

## Requirements
- R1: After reset the mode reads 01 (automatic) and the policy is 00. The applied gain then follows the automatic gain input.
- R2: The applied gain depends on the readback mode. Mode 00 gives the parameter UNITY_GAIN (default 10'h100). Mode 01 gives the live automatic gain input. Mode 10 gives the live programmed gain input.
- R3: Mode 11 (freeze) applies the automatic gain word that was present in the cycle the mode was entered. That value holds for as long as the mode stays 11.
- R4: A write with cfgWrEn high loads both the mode and the policy at the clock edge. The new mode shows on modeRd one cycle after the write.
- R5: While the mode is 01, a lock-lost pulse never changes the mode, whatever the policy.
- R6: With policy 00, a lock-lost pulse sets the mode to 01 when the mode is 00, 10 or 11.
- R7: With policy 01, or with the reserved policy 11, a lock-lost pulse leaves the mode unchanged.
- R8: With policy 10, a lock-lost pulse sets the mode to 01 only when the mode is 11. Modes 00 and 10 are kept.
- R9: With policy 10 and mode 01, a lock-achieved pulse switches the mode to 11 and captures the automatic gain word present in that cycle. A lock-achieved pulse has no effect under any other policy or in any other mode.
- R10: When a register write and a lock pulse arrive in the same cycle, the write decides the new mode and the hardware rewrite is dropped.
- R11: When lock-lost and lock-achieved arrive in the same cycle, only lock-lost is acted on.
- R12: Without a write or a lock pulse, the mode stays the same from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the mode and policy fields |
| cfgWrMode | input | 2 | Gain mode value to write |
| cfgWrPolicy | input | 2 | Lock-loss policy value to write |
| lockLost | input | 1 | Single-cycle pulse: sync lock has been lost |
| lockAchieved | input | 1 | Single-cycle pulse: sync lock has been acquired |
| agcGain | input | GAIN_W | Current word from the automatic gain loop |
| progGain | input | GAIN_W | Gain word programmed by software |
| appliedGain | output | GAIN_W | Gain word selected by the current mode |
| modeRd | output | 2 | Readback of the mode currently applied |

## Verification
The properties assume that lockLost and lockAchieved are single-cycle events and that the gain inputs may change on any cycle. The freeze check depends on the held word being independent of later changes to agcGain. The stimulus drives each pulse for exactly one cycle, changes agcGain on almost every step so that a wrongly held or wrongly live gain shows up, and drives the pulse pairs on purpose, one case at a time, to reach the priority rules of R10 and R11.

// File: rtl/gain_mode_pkg.sv
package gain_mode_pkg;

  typedef enum logic [1:0] {
    GM_UNITY  = 2'b00,
    GM_AUTO   = 2'b01,
    GM_PROG   = 2'b10,
    GM_FREEZE = 2'b11
  } gainMode_e;

  typedef enum logic [1:0] {
    LP_TO_AUTO   = 2'b00,
    LP_KEEP      = 2'b01,
    LP_AUTO_FIX  = 2'b10,
    LP_RESERVED  = 2'b11
  } lossPolicy_e;

  // control -> datapath strobes
  typedef struct packed {
    logic      captureAgc;
    gainMode_e selMode;
  } gainStrobe_t;

endpackage

// File: rtl/gain_mode_fsm.sv
module gain_mode_fsm
  import gain_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgWrMode,
  input  logic [1:0]  cfgWrPolicy,
  input  logic        lockLost,
  input  logic        lockAchieved,
  output gainStrobe_t strobe,
  output logic [1:0]  curPolicy
);

  gainMode_e   modeQ, modeD;
  lossPolicy_e policyQ, policyD;

  // next-mode decision: write first, then loss, then acquisition
  always_comb begin
    modeD   = modeQ;
    policyD = policyQ;
    if (cfgWrEn) begin
      modeD   = gainMode_e'(cfgWrMode);
      policyD = lossPolicy_e'(cfgWrPolicy);
    end else if (lockLost) begin
      if (modeQ != GM_AUTO) begin
        unique case (policyQ)
          LP_TO_AUTO:  modeD = GM_AUTO;
          LP_AUTO_FIX: if (modeQ == GM_FREEZE) modeD = GM_AUTO;
          default:     modeD = modeQ;
        endcase
      end
    end else if (lockAchieved) begin
      if (policyQ == LP_AUTO_FIX && modeQ == GM_AUTO) modeD = GM_FREEZE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= GM_AUTO;
      policyQ <= LP_TO_AUTO;
    end else begin
      modeQ   <= modeD;
      policyQ <= policyD;
    end
  end

  assign strobe.selMode    = modeQ;
  assign strobe.captureAgc = (modeD == GM_FREEZE) && (modeQ != GM_FREEZE);
  assign curPolicy         = policyQ;

endmodule

// File: rtl/gain_mode_path.sv
module gain_mode_path
  import gain_mode_pkg::*;
#(
  parameter int          GAIN_W     = 10,
  parameter logic [GAIN_W-1:0] UNITY_GAIN = GAIN_W'(1 << (GAIN_W - 2))
) (
  input  logic              clk,
  input  logic              rstN,
  input  gainStrobe_t       strobe,
  input  logic [GAIN_W-1:0] agcGain,
  input  logic [GAIN_W-1:0] progGain,
  output logic [GAIN_W-1:0] appliedGain
);

  logic [GAIN_W-1:0] holdQ;

  always_ff @(posedge clk) begin
    if (!rstN)                  holdQ <= '0;
    else if (strobe.captureAgc) holdQ <= agcGain;
  end

  always_comb begin
    unique case (strobe.selMode)
      GM_UNITY:  appliedGain = UNITY_GAIN;
      GM_AUTO:   appliedGain = agcGain;
      GM_PROG:   appliedGain = progGain;
      GM_FREEZE: appliedGain = holdQ;
      default:   appliedGain = agcGain;
    endcase
  end

endmodule

// File: rtl/gain_mode_ctrl.sv
module gain_mode_ctrl
  import gain_mode_pkg::*;
#(
  parameter int                GAIN_W     = 10,
  parameter logic [GAIN_W-1:0] UNITY_GAIN = GAIN_W'(1 << (GAIN_W - 2))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgWrMode,
  input  logic [1:0]        cfgWrPolicy,
  input  logic              lockLost,
  input  logic              lockAchieved,
  input  logic [GAIN_W-1:0] agcGain,
  input  logic [GAIN_W-1:0] progGain,
  output logic [GAIN_W-1:0] appliedGain,
  output logic [1:0]        modeRd
);

  gainStrobe_t strobe;
  logic [1:0]  curPolicy;

  gain_mode_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrEn      (cfgWrEn),
    .cfgWrMode    (cfgWrMode),
    .cfgWrPolicy  (cfgWrPolicy),
    .lockLost     (lockLost),
    .lockAchieved (lockAchieved),
    .strobe       (strobe),
    .curPolicy    (curPolicy)
  );

  gain_mode_path #(.GAIN_W(GAIN_W), .UNITY_GAIN(UNITY_GAIN)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .agcGain     (agcGain),
    .progGain    (progGain),
    .appliedGain (appliedGain)
  );

  assign modeRd = strobe.selMode;

endmodule

// File: rtl/gain_mode_ctrl_chk.sv
module gain_mode_ctrl_chk #(
  parameter int GAIN_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [1:0]        cfgWrMode,
  input logic              lockLost,
  input logic              lockAchieved,
  input logic [GAIN_W-1:0] agcGain,
  input logic [GAIN_W-1:0] appliedGain,
  input logic [1:0]        modeRd,
  input logic [1:0]        curPolicy
);

  // R4 / R10
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> modeRd == $past(cfgWrMode));

  // R5
  auto_immune_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrEn && lockLost && modeRd == 2'b01) |=> modeRd == 2'b01);

  // R6
  loss_to_auto_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrEn && lockLost && curPolicy == 2'b00) |=> modeRd == 2'b01);

  // R7
  loss_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrEn && lockLost && curPolicy[0]) |=> $stable(modeRd));

  // R3
  freeze_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeRd == 2'b11) |-> appliedGain == $past(agcGain));

  // R3
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeRd == 2'b11 && $past(modeRd) == 2'b11) |-> $stable(appliedGain));

  // R12
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrEn && !lockLost && !lockAchieved) |=> $stable(modeRd));

endmodule

bind gain_mode_ctrl gain_mode_ctrl_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgWrEn      (cfgWrEn),
  .cfgWrMode    (cfgWrMode),
  .lockLost     (lockLost),
  .lockAchieved (lockAchieved),
  .agcGain      (agcGain),
  .appliedGain  (appliedGain),
  .modeRd       (modeRd),
  .curPolicy    (curPolicy)
);

// File: tb/gain_mode_ctrl_tb.sv
module gain_mode_ctrl_tb;

  localparam int GW = 10;
  localparam logic [GW-1:0] UNITY = 10'h100;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [1:0]    cfgWrMode = '0;
  logic [1:0]    cfgWrPolicy = '0;
  logic          lockLost = 1'b0;
  logic          lockAchieved = 1'b0;
  logic [GW-1:0] agcGain = '0;
  logic [GW-1:0] progGain = '0;
  logic [GW-1:0] appliedGain;
  logic [1:0]    modeRd;

  always #2.5 clk = ~clk;

  gain_mode_ctrl #(.GAIN_W(GW), .UNITY_GAIN(UNITY)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrMode(cfgWrMode),
    .cfgWrPolicy(cfgWrPolicy), .lockLost(lockLost), .lockAchieved(lockAchieved),
    .agcGain(agcGain), .progGain(progGain), .appliedGain(appliedGain), .modeRd(modeRd)
  );

  typedef struct {
    logic [1:0]    mode;
    logic [GW-1:0] gain;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];
  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  // reference model state
  logic [1:0]    mMode = 2'b01;
  logic [1:0]    mPol = 2'b00;
  logic [GW-1:0] mHold = '0;

  task automatic step(input logic wr, input logic [1:0] wm, input logic [1:0] wp,
                      input logic lost, input logic ach,
                      input logic [GW-1:0] agc, input logic [GW-1:0] prog,
                      input string tag);
    logic [1:0] nMode;
    logic [1:0] nPol;
    expItem_t it;
    @(negedge clk);
    cfgWrEn = wr; cfgWrMode = wm; cfgWrPolicy = wp;
    lockLost = lost; lockAchieved = ach; agcGain = agc; progGain = prog;
    nMode = mMode; nPol = mPol;
    if (wr) begin
      nMode = wm; nPol = wp;
    end else if (lost) begin
      if (mMode != 2'b01) begin
        if (mPol == 2'b00) nMode = 2'b01;
        else if (mPol == 2'b10 && mMode == 2'b11) nMode = 2'b01;
      end
    end else if (ach) begin
      if (mPol == 2'b10 && mMode == 2'b01) nMode = 2'b11;
    end
    if (nMode == 2'b11 && mMode != 2'b11) mHold = agc;
    mMode = nMode; mPol = nPol;
    it.mode = nMode;
    case (nMode)
      2'b00:   it.gain = UNITY;
      2'b01:   it.gain = agc;
      2'b10:   it.gain = prog;
      default: it.gain = mHold;
    endcase
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        testsRun++;
        if (modeRd !== e.mode || appliedGain !== e.gain) begin
          testsFailed++;
          $display("FAIL %s: mode=%b gain=%h expected mode=%b gain=%h",
                   e.tag, modeRd, appliedGain, e.mode, e.gain);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    step(0, 0, 0, 0, 0, 10'h041, 10'h000, "R1");
    step(0, 0, 0, 0, 0, 10'h042, 10'h000, "R1");
    // R2 / R4 unity and programmed
    step(1, 2'b00, 2'b00, 0, 0, 10'h043, 10'h2AB, "R4");
    step(0, 0, 0, 0, 0, 10'h044, 10'h2AB, "R2");
    step(1, 2'b10, 2'b00, 0, 0, 10'h045, 10'h2AB, "R2");
    step(0, 0, 0, 0, 0, 10'h046, 10'h155, "R2");
    // R3 freeze by write
    step(1, 2'b11, 2'b00, 0, 0, 10'h155, 10'h000, "R3");
    step(0, 0, 0, 0, 0, 10'h3FF, 10'h000, "R3");
    step(0, 0, 0, 0, 0, 10'h001, 10'h000, "R3");
    // R6 policy 00 returns to automatic
    step(0, 0, 0, 1, 0, 10'h050, 10'h000, "R6");
    // R5 automatic ignores loss
    step(0, 0, 0, 1, 0, 10'h051, 10'h000, "R5");
    // R7 keep policy and reserved policy
    step(1, 2'b10, 2'b01, 0, 0, 10'h052, 10'h123, "R4");
    step(0, 0, 0, 1, 0, 10'h053, 10'h123, "R7");
    step(1, 2'b00, 2'b11, 0, 0, 10'h054, 10'h123, "R4");
    step(0, 0, 0, 1, 0, 10'h055, 10'h123, "R7");
    // R8 policy 10 on loss
    step(1, 2'b11, 2'b10, 0, 0, 10'h0AA, 10'h000, "R3");
    step(0, 0, 0, 1, 0, 10'h056, 10'h000, "R8");
    step(1, 2'b10, 2'b10, 0, 0, 10'h057, 10'h0F0, "R4");
    step(0, 0, 0, 1, 0, 10'h058, 10'h0F0, "R8");
    step(1, 2'b00, 2'b10, 0, 0, 10'h059, 10'h0F0, "R4");
    step(0, 0, 0, 1, 0, 10'h05A, 10'h0F0, "R8");
    // R9 lock achieved under policy 10
    step(0, 0, 0, 0, 1, 10'h05B, 10'h0F0, "R9");
    step(1, 2'b01, 2'b10, 0, 0, 10'h05C, 10'h000, "R4");
    step(0, 0, 0, 0, 1, 10'h0CC, 10'h000, "R9");
    step(0, 0, 0, 0, 0, 10'h333, 10'h000, "R9");
    step(1, 2'b01, 2'b00, 0, 0, 10'h05D, 10'h000, "R4");
    step(0, 0, 0, 0, 1, 10'h05E, 10'h000, "R9");
    // R10 write beats simultaneous pulse
    step(1, 2'b00, 2'b00, 0, 0, 10'h05F, 10'h000, "R4");
    step(1, 2'b10, 2'b00, 1, 0, 10'h060, 10'h0E0, "R10");
    step(1, 2'b01, 2'b10, 0, 1, 10'h061, 10'h0E0, "R10");
    // R11 loss wins over acquisition
    step(0, 0, 0, 1, 1, 10'h062, 10'h0E0, "R11");
    // R12 idle stability
    step(0, 0, 0, 0, 0, 10'h063, 10'h0E0, "R12");
    step(0, 0, 0, 0, 0, 10'h064, 10'h0E0, "R12");
    @(negedge clk);
    cfgWrEn = 0; lockLost = 0; lockAchieved = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule